// File: doc/BRIEF.md
# Constant-Rate Packet Stream Combiner

This block combines several transport packet streams into a single output stream that is drained at a fixed pace. Each input sits behind an external first-word-fall-through byte queue that flags when at least one complete 188-byte packet is waiting. A scheduler makes one decision per packet boundary. It then copies one whole packet into an internal byte FIFO. The packet comes from an input, from a small table memory that holds stored program-table packets, or from a null-packet generator.

Table packets go out on a programmable period counted in written packets. Null packets are produced only when nothing else can be sent and the FIFO is under half full, so the drain side always has bytes to send. A clock-enable tick pulls one byte per pulse from the FIFO. The result is a steady output byte rate that does not depend on how bursty the inputs are.

Top module: `tsmux_top`

## Requirements
- R1: While reset is held and on the first cycles after it, `outValid` is 0 and every bit of `inRdEn` is 0.
- R2: A generated null packet is exactly: byte 0 = 0x47, byte 1 = 0x1F, byte 2 = 0xFF, byte 3 = 0x10, and bytes 4..187 all 0xFF.
- R3: A null packet starts only when no table packet is pending, no input has a complete packet, and the FIFO level is below FIFO_DEPTH/2. With the drain stopped and no input traffic, the FIFO therefore fills with nulls only until it reaches half full or more. With the test depth of 1024 this is exactly 3 nulls.
- R4: A packet write starts only when the FIFO has at least 188 free bytes. All 188 bytes are then written on consecutive cycles, and the FIFO never overflows.
- R5: Inputs are granted in rotating order. The search starts at the input after the last one granted (input 0 after reset). Inputs without a complete packet are skipped.
- R6: With `tblPeriod` = P > 0, a table insertion becomes pending after every P packets of any kind written to the FIFO. The packet counter restarts from 0 when an insertion is raised and after reset. With P = 0, no table packet is ever sent.
- R7: Successive table insertions send stored packets 0, 1, …, TBL_PKTS-1 in turn and then wrap; packet 0 is first after reset. Table memory byte k of stored packet j is written at address j·188 + k.
- R8: At a packet boundary, a pending table packet takes precedence over input data, and input data takes precedence over null stuffing.
- R9: Each `outTick` pulse, when the FIFO is not empty, makes `outValid` high for one cycle on the following cycle, carrying the oldest byte. No byte leaves without a tick, and bytes leave in the order they were written.
- R10: `inRdEn` is zero or one-hot. Only the granted input is popped, exactly 188 times per granted packet, and its bytes reach the output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inPktRdy | input | NUM_IN (6) | Input i holds at least one complete packet, with its head byte shown on inData |
| inData | input | 8·NUM_IN (48) | Head byte of each input queue, input i in bits 8i+7..8i |
| inRdEn | output | NUM_IN (6) | Pop strobe for each input queue; the head byte is consumed on this cycle |
| tblWrEn | input | 1 | Table memory write strobe |
| tblWrAddr | input | clog2(TBL_PKTS·188) (9) | Table memory byte address |
| tblWrData | input | 8 | Table memory write byte |
| tblPeriod | input | PERIOD_W (16) | Packets between table insertions; 0 turns insertion off |
| outTick | input | 1 | Drain enable: one byte leaves per pulse |
| outValid | output | 1 | outData holds a drained byte on this cycle |
| outData | output | 8 | Drained output byte |

## Verification
The hardest situation to reach is a FIFO that is close to full, where the free-space rule and the half-full rule for stuffing both apply. Under a normal drain the level stays near empty, so neither rule is ever tested. The bench stops the drain tick entirely and lets the generator stuff the FIFO on its own until stuffing stops. It then offers three input packets. Counting pops at the input shows that only two fit. Restarting the drain then shows the third packet waiting for room and being sent ahead of any further null.

// File: rtl/tsmux_pkg.sv
package tsmux_pkg;

  localparam int unsigned PKT_BYTES = 188;
  localparam int unsigned IDX_W     = 8;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_DATA  = 2'd1,
    SRC_TABLE = 2'd2,
    SRC_NULL  = 2'd3
  } srcKind_e;

  // Per-cycle write strobes from the scheduler to the datapath
  typedef struct packed {
    logic             wrEn;
    logic             firstByte;
    logic             lastByte;
    srcKind_e         kind;
    logic [IDX_W-1:0] byteIdx;
  } wrStrobe_t;

  // Stuffing packet: sync, identifier 0x1FFF, payload-only, all-ones payload
  function automatic logic [7:0] nullByte(input logic [IDX_W-1:0] idx);
    logic [7:0] b;
    case (idx)
      8'd0:    b = 8'h47;
      8'd1:    b = 8'h1F;
      8'd2:    b = 8'hFF;
      8'd3:    b = 8'h10;
      default: b = 8'hFF;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/tsmux_ctrl.sv
module tsmux_ctrl
  import tsmux_pkg::*;
#(
  parameter int NUM_IN     = 6,
  parameter int TBL_PKTS   = 2,
  parameter int FIFO_DEPTH = 2048,
  parameter int PERIOD_W   = 16,
  localparam int SEL_W     = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int TSEL_W    = (TBL_PKTS > 1) ? $clog2(TBL_PKTS) : 1,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_IN-1:0]   inPktRdy,
  input  logic [LVL_W-1:0]    fifoLevel,
  input  logic [PERIOD_W-1:0] tblPeriod,
  output wrStrobe_t           strobe,
  output logic [SEL_W-1:0]    grantSel,
  output logic [TSEL_W-1:0]   tblSel
);

  localparam logic [LVL_W-1:0] ROOM_MAX  = LVL_W'(FIFO_DEPTH - PKT_BYTES);
  localparam logic [LVL_W-1:0] HALF_LVL  = LVL_W'(FIFO_DEPTH / 2);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(PKT_BYTES - 1);

  logic                busy;
  srcKind_e            curKind;
  logic [IDX_W-1:0]    byteIdx;
  logic [SEL_W-1:0]    rrPtr;
  logic                tblPending;
  logic [PERIOD_W-1:0] pktCnt;
  logic [NUM_IN-1:0]   rdyQ;

  logic                pickValid;
  logic [SEL_W-1:0]    pickIdx;
  logic                roomOk;
  logic                belowHalf;
  srcKind_e            startKind;

  // Rotating search: the lowest offset from rrPtr with a full packet wins
  always_comb begin
    pickValid = 1'b0;
    pickIdx   = rrPtr;
    for (int k = NUM_IN - 1; k >= 0; k--) begin
      int cand;
      cand = (int'(rrPtr) + k) % NUM_IN;
      if (inPktRdy[cand]) begin
        pickValid = 1'b1;
        pickIdx   = SEL_W'(cand);
      end
    end
  end

  assign roomOk    = (fifoLevel <= ROOM_MAX);
  assign belowHalf = (fifoLevel < HALF_LVL);

  always_comb begin
    startKind = SRC_NONE;
    if (!busy && roomOk) begin
      if (tblPending)      startKind = SRC_TABLE;
      else if (pickValid)  startKind = SRC_DATA;
      else if (belowHalf)  startKind = SRC_NULL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      curKind    <= SRC_NONE;
      byteIdx    <= '0;
      grantSel   <= '0;
      rrPtr      <= '0;
      tblPending <= 1'b0;
      tblSel     <= '0;
      pktCnt     <= '0;
    end else if (!busy) begin
      if (startKind != SRC_NONE) begin
        busy    <= 1'b1;
        curKind <= startKind;
        byteIdx <= '0;
        if (startKind == SRC_DATA) begin
          grantSel <= pickIdx;
          rrPtr    <= (pickIdx == SEL_W'(NUM_IN - 1)) ? '0 : pickIdx + 1'b1;
        end
        if (startKind == SRC_TABLE) tblPending <= 1'b0;
      end
    end else begin
      byteIdx <= byteIdx + 1'b1;
      if (byteIdx == LAST_IDX) begin
        busy    <= 1'b0;
        curKind <= SRC_NONE;
        if (curKind == SRC_TABLE)
          tblSel <= (tblSel == TSEL_W'(TBL_PKTS - 1)) ? '0 : tblSel + 1'b1;
        if (tblPeriod == '0) begin
          pktCnt <= '0;
        end else if (pktCnt >= tblPeriod - 1'b1) begin
          pktCnt     <= '0;
          tblPending <= 1'b1;
        end else begin
          pktCnt <= pktCnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdyQ <= '0;
    else       rdyQ <= inPktRdy;
  end

  always_comb begin
    strobe           = '0;
    strobe.wrEn      = busy;
    strobe.kind      = curKind;
    strobe.byteIdx   = byteIdx;
    strobe.firstByte = busy && (byteIdx == '0);
    strobe.lastByte  = busy && (byteIdx == LAST_IDX);
  end

  AST_WHOLE_PACKET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !strobe.lastByte) |=> (strobe.wrEn && strobe.kind == $past(strobe.kind))); // R4

  AST_TABLE_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.firstByte && strobe.kind == SRC_DATA) |-> !tblPending); // R8

  AST_GRANT_HAD_PACKET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.firstByte && strobe.kind == SRC_DATA) |-> rdyQ[grantSel]); // R5

  AST_KIND_DEFINED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (strobe.kind != SRC_NONE)); // R4

endmodule

// File: rtl/tsmux_dpath.sv
module tsmux_dpath
  import tsmux_pkg::*;
#(
  parameter int NUM_IN     = 6,
  parameter int TBL_PKTS   = 2,
  parameter int FIFO_DEPTH = 2048,
  localparam int SEL_W     = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int TSEL_W    = (TBL_PKTS > 1) ? $clog2(TBL_PKTS) : 1,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
  localparam int TBL_DEPTH = TBL_PKTS * PKT_BYTES,
  localparam int TBL_AW    = $clog2(TBL_DEPTH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  wrStrobe_t             strobe,
  input  logic [SEL_W-1:0]      grantSel,
  input  logic [TSEL_W-1:0]     tblSel,
  input  logic [NUM_IN*8-1:0]   inData,
  output logic [NUM_IN-1:0]     inRdEn,
  input  logic                  tblWrEn,
  input  logic [TBL_AW-1:0]     tblWrAddr,
  input  logic [7:0]            tblWrData,
  input  logic                  outTick,
  output logic                  outValid,
  output logic [7:0]            outData,
  output logic [LVL_W-1:0]      fifoLevel
);

  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam logic [LVL_W-1:0] ROOM_MAX = LVL_W'(FIFO_DEPTH - PKT_BYTES);
  localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(FIFO_DEPTH / 2);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  logic [7:0] inBytes [NUM_IN];

  for (genvar g = 0; g < NUM_IN; g++) begin : g_inLane
    assign inBytes[g] = inData[g*8 +: 8];
    assign inRdEn[g]  = strobe.wrEn && (strobe.kind == SRC_DATA) && (grantSel == SEL_W'(g));
  end

  // Table memory, loaded byte by byte
  logic [7:0]        tblMem [TBL_DEPTH];
  logic [TBL_AW-1:0] tblRdAddr;

  always_ff @(posedge clk) begin
    if (tblWrEn && (int'(tblWrAddr) < TBL_DEPTH)) tblMem[tblWrAddr] <= tblWrData;
  end

  assign tblRdAddr = TBL_AW'(tblSel) * TBL_AW'(PKT_BYTES) + TBL_AW'(strobe.byteIdx);

  // Source byte selection
  logic [7:0] wrData;
  always_comb begin
    case (strobe.kind)
      SRC_DATA:  wrData = inBytes[grantSel];
      SRC_TABLE: wrData = tblMem[tblRdAddr];
      SRC_NULL:  wrData = nullByte(strobe.byteIdx);
      default:   wrData = 8'h00;
    endcase
  end

  // Output FIFO
  logic [7:0]       fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             doWrite;
  logic             doRead;

  assign doWrite = strobe.wrEn;
  assign doRead  = outTick && (fifoLevel != '0);

  always_ff @(posedge clk) begin
    if (doWrite) fifoMem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoLevel <= '0;
      outValid  <= 1'b0;
      outData   <= '0;
    end else begin
      outValid <= doRead;
      if (doRead) begin
        outData <= fifoMem[rdPtr];
        rdPtr   <= (rdPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      end
      if (doWrite)
        wrPtr <= (wrPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      case ({doWrite, doRead})
        2'b10:   fifoLevel <= fifoLevel + 1'b1;
        2'b01:   fifoLevel <= fifoLevel - 1'b1;
        default: fifoLevel <= fifoLevel;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (fifoLevel < FULL_LVL)); // R4

  AST_START_HAS_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    strobe.firstByte |-> (fifoLevel <= ROOM_MAX)); // R4

  AST_NULL_BELOW_HALF: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.firstByte && strobe.kind == SRC_NULL) |-> (fifoLevel < HALF_LVL)); // R3

  AST_RDEN_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(inRdEn)); // R10

  AST_DRAIN_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(outTick)); // R9

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(strobe.wrEn)) |-> (fifoLevel == $past(fifoLevel) - 1'b1)); // R9

endmodule

// File: rtl/tsmux_top.sv
module tsmux_top
  import tsmux_pkg::*;
#(
  parameter int NUM_IN     = 6,
  parameter int TBL_PKTS   = 2,
  parameter int FIFO_DEPTH = 2048,
  parameter int PERIOD_W   = 16
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [NUM_IN-1:0]                      inPktRdy,
  input  logic [NUM_IN*8-1:0]                    inData,
  output logic [NUM_IN-1:0]                      inRdEn,
  input  logic                                   tblWrEn,
  input  logic [$clog2(TBL_PKTS*PKT_BYTES)-1:0]  tblWrAddr,
  input  logic [7:0]                             tblWrData,
  input  logic [PERIOD_W-1:0]                    tblPeriod,
  input  logic                                   outTick,
  output logic                                   outValid,
  output logic [7:0]                             outData
);

  localparam int SEL_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
  localparam int TSEL_W = (TBL_PKTS > 1) ? $clog2(TBL_PKTS) : 1;
  localparam int LVL_W  = $clog2(FIFO_DEPTH + 1);

  wrStrobe_t          strobe;
  logic [SEL_W-1:0]   grantSel;
  logic [TSEL_W-1:0]  tblSel;
  logic [LVL_W-1:0]   fifoLevel;

  tsmux_ctrl #(
    .NUM_IN    (NUM_IN),
    .TBL_PKTS  (TBL_PKTS),
    .FIFO_DEPTH(FIFO_DEPTH),
    .PERIOD_W  (PERIOD_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inPktRdy (inPktRdy),
    .fifoLevel(fifoLevel),
    .tblPeriod(tblPeriod),
    .strobe   (strobe),
    .grantSel (grantSel),
    .tblSel   (tblSel)
  );

  tsmux_dpath #(
    .NUM_IN    (NUM_IN),
    .TBL_PKTS  (TBL_PKTS),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .grantSel (grantSel),
    .tblSel   (tblSel),
    .inData   (inData),
    .inRdEn   (inRdEn),
    .tblWrEn  (tblWrEn),
    .tblWrAddr(tblWrAddr),
    .tblWrData(tblWrData),
    .outTick  (outTick),
    .outValid (outValid),
    .outData  (outData),
    .fifoLevel(fifoLevel)
  );

endmodule

// File: tb/tsmux_top_tb_top.sv
module tsmux_top_tb_top;

  localparam int NIN    = 6;
  localparam int NTBL   = 2;
  localparam int DEPTH  = 1024;
  localparam int PLEN   = 188;
  localparam int TAW    = $clog2(NTBL * PLEN);
  localparam int QMAX   = 4096;
  localparam int CAPMAX = 16384;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NIN-1:0]    inPktRdy = '0;
  logic [NIN*8-1:0]  inData = '0;
  logic [NIN-1:0]    inRdEn;
  logic              tblWrEn = 1'b0;
  logic [TAW-1:0]    tblWrAddr = '0;
  logic [7:0]        tblWrData = '0;
  logic [15:0]       tblPeriod = '0;
  logic              outTick = 1'b0;
  logic              outValid;
  logic [7:0]        outData;

  always #10 clk = ~clk;

  tsmux_top #(
    .NUM_IN(NIN), .TBL_PKTS(NTBL), .FIFO_DEPTH(DEPTH), .PERIOD_W(16)
  ) dut_i (
    .clk(clk), .rstN(rstN), .inPktRdy(inPktRdy), .inData(inData), .inRdEn(inRdEn),
    .tblWrEn(tblWrEn), .tblWrAddr(tblWrAddr), .tblWrData(tblWrData),
    .tblPeriod(tblPeriod), .outTick(outTick), .outValid(outValid), .outData(outData)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [7:0] qMem [NIN][QMAX];
  int qHead [NIN];
  int qTail [NIN];
  int popCnt = 0;

  logic [7:0] cap [CAPMAX];
  int capN = 0;
  bit prevValid = 1'b0;
  int backToBack = 0;

  int tickMode = 0;
  int tickCnt = 0;
  int tickIssued = 0;

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  function automatic logic [7:0] dataByte(input int port, input int sq, input int k);
    case (k)
      0: return 8'h47;
      1: return 8'(port);
      2: return 8'(sq);
      3: return 8'h10;
      default: return 8'((k ^ (port << 4) ^ sq) & 255);
    endcase
  endfunction

  function automatic logic [7:0] tblByte(input int idx, input int k);
    case (k)
      0: return 8'h47;
      1: return 8'(8'h40 | idx);
      2: return 8'h00;
      3: return 8'h10;
      default: return 8'((k * 3 + idx * 7) & 255);
    endcase
  endfunction

  function automatic void refresh();
    for (int i = 0; i < NIN; i++) begin
      inPktRdy[i] = (qTail[i] - qHead[i]) >= PLEN;
      inData[i*8 +: 8] = (qTail[i] > qHead[i]) ? qMem[i][qHead[i]] : 8'h00;
    end
  endfunction

  // Input queue model: a pop seen on one half cycle is applied on the next
  initial begin
    logic [NIN-1:0] pend;
    pend = '0;
    for (int i = 0; i < NIN; i++) begin qHead[i] = 0; qTail[i] = 0; end
    forever begin
      @(negedge clk);
      for (int i = 0; i < NIN; i++) if (pend[i]) begin qHead[i]++; popCnt++; end
      pend = inRdEn;
      refresh();
    end
  end

  // Output capture
  initial begin
    forever begin
      @(negedge clk);
      if (outValid) begin
        if (capN < CAPMAX) cap[capN] = outData;
        capN++;
        if (prevValid) backToBack++;
      end
      prevValid = outValid;
    end
  end

  // Drain tick generator
  initial begin
    forever begin
      @(negedge clk);
      tickCnt++;
      outTick = (tickMode != 0) && ((tickCnt % tickMode) == 0);
      if (outTick) tickIssued++;
    end
  end

  function automatic int pktCode(input int n);
    int base;
    bit ok;
    int idx;
    int port;
    int sq;
    base = n * PLEN;
    if (base + PLEN > capN) return -1;
    if (cap[base] != 8'h47) return 99;
    ok = 1'b1;
    for (int k = 0; k < PLEN; k++)
      if (cap[base+k] != ((k == 0) ? 8'h47 : (k == 1) ? 8'h1F : (k == 3) ? 8'h10 : 8'hFF)) ok = 1'b0;
    if (ok) return 20;
    if (cap[base+1][7:4] == 4'h4) begin
      idx = int'(cap[base+1][3:0]);
      for (int k = 0; k < PLEN; k++) if (cap[base+k] != tblByte(idx, k)) return 98;
      return 10 + idx;
    end
    port = int'(cap[base+1]);
    sq   = int'(cap[base+2]);
    if (port >= NIN) return 97;
    for (int k = 0; k < PLEN; k++) if (cap[base+k] != dataByte(port, sq, k)) return 96;
    return port;
  endfunction

  task automatic checkPkt(input int n, input int expCode, input int expSeq, input string req);
    int code;
    int sq;
    code = pktCode(n);
    sq = (code >= 0 && code < NIN) ? int'(cap[n*PLEN+2]) : expSeq;
    check(code == expCode && sq == expSeq, req, code * 100 + sq, expCode * 100 + expSeq);
  endtask

  task automatic pushPkt(input int port, input int sq);
    for (int k = 0; k < PLEN; k++) begin
      qMem[port][qTail[port]] = dataByte(port, sq, k);
      qTail[port]++;
    end
    refresh();
  endtask

  task automatic startReset(input int period);
    @(negedge clk);
    rstN = 1'b0;
    tickMode = 0;
    tblPeriod = 16'(period);
    for (int i = 0; i < NIN; i++) begin qHead[i] = 0; qTail[i] = 0; end
    refresh();
    repeat (3) @(negedge clk);
    capN = 0;
    popCnt = 0;
    tickIssued = 0;
    backToBack = 0;
  endtask

  task automatic endReset();
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testReset();
    startReset(0);
    check(outValid == 1'b0, "R1 outValid in reset", int'(outValid), 0);
    check(inRdEn == '0, "R1 inRdEn in reset", int'(inRdEn), 0);
    endReset();
    repeat (2) @(negedge clk);
    check(outValid == 1'b0, "R1 outValid after reset", int'(outValid), 0);
    check(inRdEn == '0, "R1 inRdEn after reset", int'(inRdEn), 0);
  endtask

  task automatic testNullDrain();
    startReset(0);
    endReset();
    repeat (300) @(negedge clk);
    tickIssued = 0;
    capN = 0;
    backToBack = 0;
    tickMode = 3;
    repeat (1200) @(negedge clk);
    tickMode = 0;
    repeat (5) @(negedge clk);
    check(capN == tickIssued, "R9 one byte per tick", capN, tickIssued);
    check(backToBack == 0, "R9 no byte without tick", backToBack, 0);
    for (int n = 0; n < 2; n++) checkPkt(n, 20, 0, "R2 null packet content");
  endtask

  task automatic testThreshold();
    startReset(0);
    endReset();
    repeat (800) @(negedge clk);
    pushPkt(0, 0);
    pushPkt(0, 1);
    pushPkt(0, 2);
    repeat (800) @(negedge clk);
    check(popCnt == 2 * PLEN, "R4 only packets with room start", popCnt, 2 * PLEN);
    tickMode = 1;
    repeat (1500) @(negedge clk);
    tickMode = 0;
    for (int n = 0; n < 3; n++) checkPkt(n, 20, 0, "R3 nulls up to half full");
    for (int n = 0; n < 3; n++) checkPkt(3 + n, 0, n, "R8 data ahead of null");
    checkPkt(6, 20, 0, "R3 stuffing resumes when idle");
    check(popCnt == 3 * PLEN, "R10 pops per packet", popCnt, 3 * PLEN);
  endtask

  task automatic testRoundRobin();
    startReset(0);
    pushPkt(0, 0); pushPkt(0, 1);
    pushPkt(2, 0); pushPkt(2, 1);
    pushPkt(5, 0); pushPkt(5, 1);
    endReset();
    tickMode = 1;
    repeat (1700) @(negedge clk);
    tickMode = 0;
    checkPkt(0, 0, 0, "R5 rotation slot 0");
    checkPkt(1, 2, 0, "R5 rotation skips empty input");
    checkPkt(2, 5, 0, "R5 rotation slot 2");
    checkPkt(3, 0, 1, "R5 rotation wraps");
    checkPkt(4, 2, 1, "R10 bytes unchanged");
    checkPkt(5, 5, 1, "R10 bytes unchanged");
    checkPkt(6, 20, 0, "R6 period 0 sends no table");
    check(popCnt == 6 * PLEN, "R10 pop count", popCnt, 6 * PLEN);
  endtask

  task automatic testTable();
    startReset(3);
    for (int j = 0; j < NTBL; j++) begin
      for (int k = 0; k < PLEN; k++) begin
        tblWrEn = 1'b1;
        tblWrAddr = TAW'(j * PLEN + k);
        tblWrData = tblByte(j, k);
        @(negedge clk);
      end
    end
    tblWrEn = 1'b0;
    for (int s = 0; s < 8; s++) pushPkt(1, s);
    endReset();
    tickMode = 1;
    repeat (14 * 189 + 300) @(negedge clk);
    tickMode = 0;
    checkPkt(0, 1, 0, "R6 data before first insertion");
    checkPkt(1, 1, 1, "R6 data before first insertion");
    checkPkt(2, 1, 2, "R6 data before first insertion");
    checkPkt(3, 10, 0, "R8 table wins over ready data");
    checkPkt(4, 1, 3, "R6 count restarts");
    checkPkt(5, 1, 4, "R6 count restarts");
    checkPkt(6, 11, 0, "R7 second stored packet");
    checkPkt(7, 1, 5, "R6 data between insertions");
    checkPkt(8, 1, 6, "R6 data between insertions");
    checkPkt(9, 10, 0, "R7 table rotation wraps");
    checkPkt(10, 1, 7, "R6 last data packet");
    checkPkt(11, 20, 0, "R3 null when idle");
    checkPkt(12, 11, 0, "R6 nulls counted in period");
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    testReset();
    testNullDrain();
    testThreshold();
    testRoundRobin();
    testTable();
    finishRun();
  end

endmodule